// File: doc/BRIEF.md
# General-Purpose I/O Port with Level-Change Interrupts

This block controls a small bank of general-purpose pins (12 by default, at most 16). Software reaches it over a simple register bus. Each pin's register bits are split into a low half (pins 0 to 7) and a high half (pins 8 and up). Each pin is either an output, driven from a data register, or an input, sampled by the system clock through a two-stage synchronizer.

Any level change on an input pin can set that pin's pending-event bit, unless the pin's mask bit blocks it. Software finds the source by reading the pending-event registers, and a read clears the half it returns. A single summary flag is raised while any unmasked event is pending. The flag drives the interrupt output and is also readable as bit 0 of a global status word.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, every pin is an input (`pin_oe_o` all zero), the output data is zero, every mask bit is 1, no event is pending and `irq_o` is 0. Register reads return the implemented pins as ones for direction and mask, and zero for events.
- R2: Direction bit 0 makes a pin an output and bit 1 makes it an input. `pin_oe_o[i]` is the inverse of the direction bit and `pin_o[i]` is data bit i. Both take their new value on the clock edge that performs the write.
- R3: A read of the level register returns, per pin, the synchronized input level for input pins and the data bit for output pins. An input change becomes readable two clock edges after it is applied.
- R4: A rise or a fall on an unmasked input pin sets that pin's event bit, and only that bit, on the third clock edge after the change (two synchronizer stages plus the compare).
- R5: A pin whose mask bit is 1, or a pin configured as output, never sets its event bit when its input toggles.
- R6: The summary flag is 1 exactly when some event bit is pending with its mask bit 0. It drives `irq_o` and reads as bit 0 of address 8. Masking a pending pin drops the flag without discarding the event.
- R7: Reading event half 6 (pins 0 to 7) or 7 (pins 8 and up) returns that half's bits and clears them, leaving the other half untouched.
- R8: An event that sets on the same edge as a read of its half is retained and appears on the next read.
- R9: Address map: 0/1 direction low/high, 2/3 level (read) or data (write) low/high, 4/5 mask low/high, 6/7 events low/high, 8 global status. Bit k of a high-half register is pin 8+k. Unimplemented bits and addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; inputs sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data (one register half) |
| bus_rdata_o | output | 8 | Read data, registered, valid after the read edge |
| pin_i | input | NPINS | Asynchronous pin levels from the pads |
| pin_o | output | NPINS | Output levels to the pads |
| pin_oe_o | output | NPINS | Output enable per pin, 1 = drive |
| irq_o | output | 1 | Summary interrupt flag |

## Verification
Register writes take effect on the strobed edge. Read data is captured on the read edge, so the bench samples both one half-cycle after that edge. A pin change applied at a falling edge becomes visible in the level register after two rising edges, and its event bit and `irq_o` appear after the third. The bench therefore checks that `irq_o` is still low after the second edge and high after the third. The collision case places the read strobe on exactly that third edge and expects the first read to be empty and the second to hold the bit.

// File: rtl/gpio_port_pkg.sv
// Package: shared register-address encoding and geometry for the GPIO port.
// Assumes the bus is one register half (HALF_W bits) wide.
package gpio_port_pkg;
    localparam int HALF_W = 8;
    localparam int ADDR_W = 4;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t RA_DIR_LO = 4'd0;
    localparam reg_addr_t RA_DIR_HI = 4'd1;
    localparam reg_addr_t RA_LVL_LO = 4'd2;
    localparam reg_addr_t RA_LVL_HI = 4'd3;
    localparam reg_addr_t RA_MSK_LO = 4'd4;
    localparam reg_addr_t RA_MSK_HI = 4'd5;
    localparam reg_addr_t RA_EVT_LO = 4'd6;
    localparam reg_addr_t RA_EVT_HI = 4'd7;
    localparam reg_addr_t RA_GLB    = 4'd8;
endpackage

// File: rtl/gpio_port_sync.sv
// Module: two-flop synchronizer for W asynchronous pin levels.
// Assumes each bit is independent; no bus coherency is needed across bits.
module gpio_port_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift pad levels through two clocked stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

    // R3: synchronized value equals the pad value two edges earlier
    a_r3_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_q == $past(async_i, 2)));
endmodule

// File: rtl/gpio_port_evt.sv
// Module: per-pin change detection and pending-event bits.
// Detects any change of the synchronized level against the previous sample.
// Only input, unmasked pins record an event. Clear requests and new events
// in the same cycle resolve in favour of the new event.
module gpio_port_evt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] evt_q;
    logic [W-1:0] hit;

    assign hit = (smp_i ^ prev_q) & dir_i & ~mask_i;

    // Remember the last synchronized sample for the compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp_i;
    end

    // Update pending events: clear on read, new events always win.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_i) | hit;
    end

    assign evt_o = evt_q;
    assign hit_o = hit;

    // R5: a masked or output pin never gains a new event bit
    a_r5_blocked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~$past(evt_q) & ($past(mask_i) | ~$past(dir_i))) == '0));
    // R7: a cleared bit stays clear unless a new event hit it
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & $past(clr_i) & ~$past(hit)) == '0));
    // R8: every detected event is pending on the next cycle
    a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((~evt_q & $past(hit)) == '0));
endmodule

// File: rtl/gpio_port_regs.sv
// Module: register file and bus decode for direction, data and mask,
// plus read mux and clear-on-read strobes for the event halves.
// Assumes HALF_W < NPINS <= 2*HALF_W. Read data is registered.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  reg_addr_t         addr_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic [NPINS-1:0]  smp_i,
    input  logic [NPINS-1:0]  evt_i,
    input  logic              summary_i,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  dout_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  clr_o,
    output logic [HALF_W-1:0] rdata_o
);
    localparam int PAD = 2 * HALF_W;

    logic [NPINS-1:0]  dir_q, dout_q, mask_q;
    logic [NPINS-1:0]  wbit, dir_we, dat_we, msk_we, clr;
    logic [NPINS-1:0]  lvl;
    logic [PAD-1:0]    dir_pad, lvl_pad, msk_pad, evt_pad;
    logic [HALF_W-1:0] rd_mux;
    logic [HALF_W-1:0] rdata_q;

    // Per-pin lane decode: pick the half and the bit within the half.
    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        localparam bit        IS_HI = (i >= HALF_W);
        localparam int        LBIT  = i % HALF_W;
        localparam reg_addr_t A_DIR = IS_HI ? RA_DIR_HI : RA_DIR_LO;
        localparam reg_addr_t A_DAT = IS_HI ? RA_LVL_HI : RA_LVL_LO;
        localparam reg_addr_t A_MSK = IS_HI ? RA_MSK_HI : RA_MSK_LO;
        localparam reg_addr_t A_EVT = IS_HI ? RA_EVT_HI : RA_EVT_LO;
        assign wbit[i]   = wdata_i[LBIT];
        assign dir_we[i] = wr_en_i && (addr_i == A_DIR);
        assign dat_we[i] = wr_en_i && (addr_i == A_DAT);
        assign msk_we[i] = wr_en_i && (addr_i == A_MSK);
        assign clr[i]    = rd_en_i && (addr_i == A_EVT);
    end

    // Hold direction, output data and mask; load per-lane on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            dout_q <= '0;
            mask_q <= '1;
        end else begin
            dir_q  <= (dir_q  & ~dir_we) | (wbit & dir_we);
            dout_q <= (dout_q & ~dat_we) | (wbit & dat_we);
            mask_q <= (mask_q & ~msk_we) | (wbit & msk_we);
        end
    end

    // Present pin level: sampled input or driven data.
    assign lvl = (dir_q & smp_i) | (~dir_q & dout_q);

    assign dir_pad = PAD'(dir_q);
    assign lvl_pad = PAD'(lvl);
    assign msk_pad = PAD'(mask_q);
    assign evt_pad = PAD'(evt_i);

    // Select the addressed half; unmapped addresses read zero.
    always_comb begin
        case (addr_i)
            RA_DIR_LO: rd_mux = dir_pad[HALF_W-1:0];
            RA_DIR_HI: rd_mux = dir_pad[PAD-1:HALF_W];
            RA_LVL_LO: rd_mux = lvl_pad[HALF_W-1:0];
            RA_LVL_HI: rd_mux = lvl_pad[PAD-1:HALF_W];
            RA_MSK_LO: rd_mux = msk_pad[HALF_W-1:0];
            RA_MSK_HI: rd_mux = msk_pad[PAD-1:HALF_W];
            RA_EVT_LO: rd_mux = evt_pad[HALF_W-1:0];
            RA_EVT_HI: rd_mux = evt_pad[PAD-1:HALF_W];
            RA_GLB:    rd_mux = {{(HALF_W-1){1'b0}}, summary_i};
            default:   rd_mux = '0;
        endcase
    end

    // Capture read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign dir_o   = dir_q;
    assign dout_o  = dout_q;
    assign mask_o  = mask_q;
    assign clr_o   = clr;
    assign rdata_o = rdata_q;

    // R1: the cycle after reset all pins are inputs and all masks set
    a_r1_reset_values: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n && $past(rst_n, 2) == 1'b0) |->
        (dir_q == '1 && mask_q == '1 && dout_q == '0));
    // R2: a write to the low direction half lands on the next edge
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i) && $past(addr_i) == RA_DIR_LO) |->
        (dir_q[HALF_W-1:0] == $past(wdata_i)));
endmodule

// File: rtl/gpio_port.sv
// Module: top of the GPIO port. Synchronizes pads, detects changes,
// holds the register file and exports the summary interrupt flag.
// Assumes HALF_W < NPINS <= 2*HALF_W and a single clock domain for the bus.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [HALF_W-1:0] bus_wdata_i,
    output logic [HALF_W-1:0] bus_rdata_o,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic              irq_o
);
    logic [NPINS-1:0] smp, dir, dout, mask, clr, evt, hit;
    logic             summary;

    gpio_port_sync #(.W(NPINS)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (smp)
    );

    gpio_port_evt #(.W(NPINS)) i_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (smp),
        .dir_i  (dir),
        .mask_i (mask),
        .clr_i  (clr),
        .evt_o  (evt),
        .hit_o  (hit)
    );

    gpio_port_regs #(.NPINS(NPINS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (bus_wr_i),
        .rd_en_i   (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .smp_i     (smp),
        .evt_i     (evt),
        .summary_i (summary),
        .dir_o     (dir),
        .dout_o    (dout),
        .mask_o    (mask),
        .clr_o     (clr),
        .rdata_o   (bus_rdata_o)
    );

    // Summary: any pending event whose mask bit is clear.
    assign summary  = |(evt & ~mask);
    assign irq_o    = summary;
    assign pin_o    = dout;
    assign pin_oe_o = ~dir;

    // R6: the flag only rises after a detected event or a mask change
    a_r6_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(hit) != '0 || $past(mask) != mask));
    // R4: a new event always stems from a change on a synchronized input
    a_r4_event_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~$past(evt)) != '0) |-> ($past(smp) != $past(smp, 2)));
endmodule

// File: tb/test_gpio_port.sv
// Bench: sweeps every pin and edge direction plus register patterns on the
// default 12-pin configuration; expected values are derived from the spec.
module test_gpio_port;
    localparam int NP = 12;
    localparam logic [NP-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pin_i = '0, pin_o, pin_oe;
    logic          irq;
    int            n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    gpio_port #(.NPINS(NP)) i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]    rv;
        logic [NP-1:0] dirv, datv, expv;
        logic [15:0]   got;
        wait_cyc(3);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check("R1 oe", 32'(pin_oe), 0);
        check("R1 out", 32'(pin_o), 0);
        check("R1 irq", 32'(irq), 0);
        bus_read(4'd0, rv); check("R1 dir lo", 32'(rv), 32'hff);
        bus_read(4'd1, rv); check("R1 dir hi", 32'(rv), 32'h0f);
        bus_read(4'd4, rv); check("R1 msk lo", 32'(rv), 32'hff);
        bus_read(4'd5, rv); check("R1 msk hi", 32'(rv), 32'h0f);
        bus_read(4'd6, rv); check("R1 evt lo", 32'(rv), 0);
        bus_read(4'd7, rv); check("R1 evt hi", 32'(rv), 0);

        // R2 / R3 direction, output and level patterns
        for (int p = 0; p < 6; p++) begin
            dirv  = NP'(12'h5a3 * (p + 1) ^ 12'h0f0);
            datv  = NP'(12'h9c6 + 12'h137 * p);
            pin_i = NP'(12'h3e1 ^ (12'h111 * p));
            bus_write(4'd0, dirv[7:0]);
            bus_write(4'd1, {4'h0, dirv[11:8]});
            bus_write(4'd2, datv[7:0]);
            bus_write(4'd3, {4'h0, datv[11:8]});
            check("R2 oe", 32'(pin_oe), 32'(~dirv & ALL));
            check("R2 out", 32'(pin_o), 32'(datv));
            wait_cyc(2);
            expv = (dirv & pin_i) | (~dirv & datv);
            bus_read(4'd2, rv); got[7:0] = rv;
            bus_read(4'd3, rv); got[15:8] = rv;
            check("R3 level", 32'(got), 32'(expv));
        end

        // R4 every pin, both edges, exact timing
        bus_write(4'd0, 8'hff); bus_write(4'd1, 8'h0f);
        pin_i = '0; wait_cyc(4);
        bus_write(4'd4, 8'h00); bus_write(4'd5, 8'h00);
        bus_read(4'd6, rv); bus_read(4'd7, rv);
        for (int i = 0; i < NP; i++) begin
            for (int e = 0; e < 2; e++) begin
                @(negedge clk); pin_i[i] = ~pin_i[i];
                wait_cyc(2);
                check("R4 not before third edge", 32'(irq), 0);
                wait_cyc(1);
                check("R4 irq at third edge", 32'(irq), 1);
                bus_read(4'd6, rv); got[7:0] = rv;
                if (i >= 8) check("R7 hi kept after lo read", 32'(irq), 1);
                bus_read(4'd7, rv); got[15:8] = rv;
                check("R4 one-hot event", 32'(got), 32'(1) << i);
                check("R7 cleared", 32'(irq), 0);
            end
        end

        // R5 masked pin and output pin
        bus_write(4'd4, 8'h08);
        @(negedge clk); pin_i[3] = ~pin_i[3];
        wait_cyc(4);
        check("R5 masked irq", 32'(irq), 0);
        bus_read(4'd6, rv); check("R5 masked evt", 32'(rv), 0);
        bus_write(4'd4, 8'h00);
        bus_write(4'd0, 8'hdf);
        @(negedge clk); pin_i[5] = ~pin_i[5];
        wait_cyc(4);
        bus_read(4'd6, rv); check("R5 output pin evt", 32'(rv), 0);
        bus_write(4'd0, 8'hff); wait_cyc(3);
        bus_read(4'd6, rv);

        // R6 summary vs mask and global register
        @(negedge clk); pin_i[9] = ~pin_i[9];
        wait_cyc(3);
        check("R6 irq set", 32'(irq), 1);
        bus_read(4'd8, rv); check("R6 glb set", 32'(rv), 1);
        bus_write(4'd5, 8'h02);
        check("R6 masked drops irq", 32'(irq), 0);
        bus_read(4'd8, rv); check("R6 glb masked", 32'(rv), 0);
        bus_write(4'd5, 8'h00);
        check("R6 unmask restores irq", 32'(irq), 1);
        bus_read(4'd7, rv); check("R6 event kept", 32'(rv), 8'h02);

        // R7 halves independent
        @(negedge clk); pin_i[1] = ~pin_i[1]; pin_i[10] = ~pin_i[10];
        wait_cyc(3);
        bus_read(4'd6, rv); check("R7 lo half", 32'(rv), 8'h02);
        bus_read(4'd7, rv); check("R7 hi half", 32'(rv), 8'h04);
        bus_read(4'd6, rv); check("R7 lo cleared", 32'(rv), 0);

        // R8 event landing on the read edge
        @(negedge clk); pin_i[2] = ~pin_i[2];
        wait_cyc(2);
        bus_rd = 1'b1; bus_addr = 4'd6;
        @(negedge clk); bus_rd = 1'b0;
        check("R8 first read empty", 32'(bus_rdata), 0);
        check("R8 irq pending", 32'(irq), 1);
        bus_read(4'd6, rv); check("R8 retained", 32'(rv), 8'h04);

        // R9 unmapped addresses and bits
        bus_write(4'd9, 8'hff);
        bus_write(4'd1, 8'hf0);
        bus_read(4'd1, rv); check("R9 hi padding", 32'(rv), 0);
        bus_read(4'd0, rv); check("R9 unmapped write", 32'(rv), 8'hff);
        bus_read(4'd4, rv); check("R9 mask untouched", 32'(rv), 0);
        bus_read(4'd10, rv); check("R9 unmapped read", 32'(rv), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule